// File: doc/BRIEF.md
# Dual-Output Funnel Shift Unit

This block performs one word-step of a right shift over a number that spans many words. Each step takes a source word, a shift operand and a carry-in word. It returns two words. The first is the source shifted right, with its vacated top bits filled from the top of the carry-in word. The second is a spill word that holds the source bits pushed out at the bottom, placed at its top end.

Words are chained by feeding the spill word of one word into the carry-in of the next lower-significance word. A whole multi-word operand can then be shifted by any amount below the word width, one word per step. The datapath uses one right rotate of the source word and one mask, not a double-width shifter. A parameter selects an output register with a valid pulse or a purely combinational path.

Top module: `funnel_spill_shifter`

## Requirements
- R1: The shift count n is the low log2(W) bits of `b_i` (0 to 63 at W=64). All higher bits of `b_i` have no effect on either output.
- R2: The low W-n bits of `t_o` equal `a_i` shifted right logically by n.
- R3: The top n bits of `t_o` equal the top n bits of `c_i`, at the same bit positions.
- R4: The top n bits of `s_o` equal the low n bits of `a_i`, in order. All other bits of `s_o` are zero.
- R5: When n is 0, `t_o` equals `a_i` and `s_o` is zero, whatever `c_i` holds.
- R6: With REG_OUT=1, a cycle with `in_valid` high captures both results together. `out_valid` is high exactly in the following cycle.
- R7: With REG_OUT=1, `t_o` and `s_o` keep their values through cycles in which `in_valid` is low.
- R8: With REG_OUT=1, active-low reset clears `out_valid`, `t_o` and `s_o` to zero.
- R9: With REG_OUT=0, the outputs follow the inputs in the same cycle and `out_valid` mirrors `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| a_i | input | W | Source word |
| b_i | input | W | Shift operand; only the low log2(W) bits are used |
| c_i | input | W | Carry-in word (spill of the next higher word) |
| out_valid | output | 1 | Results valid |
| t_o | output | W | Shifted result word |
| s_o | output | W | Spill word carrying the shifted-out bits |

## Verification
An 8-bit combinational instance is swept over every source value and every shift count, with carry-in values of all zeros, all ones and an alternating pattern. This separates the bits taken from the source from the bits taken from the carry-in at each count. A 64-bit registered instance gets counts 0, 1 and 63, all-ones data, and random words with the upper shift-operand bits set. These show the mask edges, the masking of the count and the absence of any dependence on unused bits. The reference builds a double-width value, shifts it and slices it. A three-word chain confirms that spill words join correctly into a multi-word shift, and idle cycles with changing inputs show that the register holds.

// File: rtl/funsh_pkg.sv
package funsh_pkg;
    localparam int unsigned FUNSH_DEF_WIDTH = 64;

    function automatic int unsigned funsh_cnt_bits(input int unsigned w);
        return $clog2(w);
    endfunction
endpackage

// File: rtl/funsh_rotr.sv
module funsh_rotr #(
    parameter int unsigned W   = 64,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stg [SHW+1];

    assign stg[0] = din;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        assign stg[k+1] = amt[k] ? {stg[k][STEP-1:0], stg[k][W-1:STEP]} : stg[k];
    end

    assign dout = stg[SHW];
endmodule

// File: rtl/funsh_mask.sv
module funsh_mask #(
    parameter int unsigned W   = 64,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   keep_lo
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    assign keep_lo = ALL1 >> amt;
endmodule

// File: rtl/funsh_merge.sv
module funsh_merge #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] rot,
    input  logic [W-1:0] keep_lo,
    input  logic [W-1:0] cin,
    output logic [W-1:0] res,
    output logic [W-1:0] spill
);
    assign res   = (rot & keep_lo) | (cin & ~keep_lo);
    assign spill = rot & ~keep_lo;
endmodule

// File: rtl/funnel_spill_shifter.sv
module funnel_spill_shifter
    import funsh_pkg::*;
#(
    parameter int unsigned W       = FUNSH_DEF_WIDTH,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic         out_valid,
    output logic [W-1:0] t_o,
    output logic [W-1:0] s_o
);
    localparam int unsigned SHW = funsh_cnt_bits(W);

    logic [SHW-1:0] cnt;
    logic [W-1:0]   rot_w;
    logic [W-1:0]   keep_w;
    logic [W-1:0]   res_w;
    logic [W-1:0]   spill_w;
    logic           unused_b_hi;

    assign cnt         = b_i[SHW-1:0];
    assign unused_b_hi = ^b_i[W-1:SHW];

    funsh_rotr #(.W(W), .SHW(SHW)) u_rotr (
        .din  (a_i),
        .amt  (cnt),
        .dout (rot_w)
    );

    funsh_mask #(.W(W), .SHW(SHW)) u_mask (
        .amt     (cnt),
        .keep_lo (keep_w)
    );

    funsh_merge #(.W(W)) u_merge (
        .rot     (rot_w),
        .keep_lo (keep_w),
        .cin     (c_i),
        .res     (res_w),
        .spill   (spill_w)
    );

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic         vld;
            logic [W-1:0] t;
            logic [W-1:0] s;
        } stage_t;

        stage_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.t = res_w;
                st_d.s = spill_w;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign out_valid = st_q.vld;
        assign t_o       = st_q.t;
        assign s_o       = st_q.s;
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign out_valid      = in_valid;
        assign t_o            = res_w;
        assign s_o            = spill_w;
    end
endmodule

// File: rtl/funsh_checker.sv
module funsh_checker #(
    parameter int unsigned W       = 64,
    parameter bit          REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] c_i,
    input logic         out_valid,
    input logic [W-1:0] t_o,
    input logic [W-1:0] s_o
);
    localparam int unsigned SHW = $clog2(W);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic [SHW-1:0] n_in;
    logic [W-1:0]   hi_sel;
    assign n_in   = b_i[SHW-1:0];
    assign hi_sel = ~(ALL1 >> n_in);

    if (REG_OUT) begin : g_seq
        // R6: a valid input produces a valid output one cycle later
        p_valid_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R6: no output valid without an input valid the cycle before
        p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R7: idle cycles leave both result words untouched
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(t_o) && $stable(s_o)));
        // R5: zero count passes the source through with an empty spill
        p_zero_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && n_in == '0) |=> (t_o == $past(a_i) && s_o == '0));
        // R3: top bits of the result come from the carry-in word
        p_carry_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (((t_o ^ $past(c_i)) & $past(hi_sel)) == '0));
        // R4: spill never holds more ones than the source had, and only in its top part
        p_spill_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (($countones(s_o) <= $past($countones(a_i)))
                          && ((s_o & ~$past(hi_sel)) == '0)));
    end else begin : g_imm
        always_comb begin
            if (rst_n) begin
                // R9: valid passes straight through
                p_valid_pass_r9: assert (out_valid == in_valid);
                // R4: spill confined to the top n bits
                p_spill_r4: assert ((s_o & ~hi_sel) == '0);
                // R3: top n bits of the result come from the carry-in word
                p_carry_top_r3: assert (((t_o ^ c_i) & hi_sel) == '0);
            end
        end
    end
endmodule

bind funnel_spill_shifter funsh_checker #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_i       (a_i),
    .b_i       (b_i),
    .c_i       (c_i),
    .out_valid (out_valid),
    .t_o       (t_o),
    .s_o       (s_o)
);

// File: tb/funnel_spill_shifter_bench.sv
`timescale 1ns/1ps
module funnel_spill_shifter_bench;
    localparam int unsigned WB = 64;
    localparam int unsigned WS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // 64-bit registered instance
    logic          iv;
    logic [WB-1:0] a, b, c;
    logic          ov;
    logic [WB-1:0] t, s;

    funnel_spill_shifter #(.W(WB), .REG_OUT(1'b1)) u_funnel_spill_shifter (
        .clk(clk), .rst_n(rst_n), .in_valid(iv), .a_i(a), .b_i(b), .c_i(c),
        .out_valid(ov), .t_o(t), .s_o(s)
    );

    // 8-bit combinational instance
    logic          iv8;
    logic [WS-1:0] a8, b8, c8;
    logic          ov8;
    logic [WS-1:0] t8, s8;

    funnel_spill_shifter #(.W(WS), .REG_OUT(1'b0)) u_funnel_spill_shifter_small (
        .clk(clk), .rst_n(rst_n), .in_valid(iv8), .a_i(a8), .b_i(b8), .c_i(c8),
        .out_valid(ov8), .t_o(t8), .s_o(s8)
    );

    // Reference: build {a, zeros} as a double-width value, shift, slice.
    function automatic void ref_calc(input int unsigned w, input logic [63:0] av,
                                     input logic [63:0] bv, input logic [63:0] cv,
                                     output logic [63:0] tv, output logic [63:0] sv);
        logic [127:0] wide;
        logic [63:0]  wm, keep;
        int unsigned  n;
        wm   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        n    = int'(bv % 64'(w));
        wide = ({64'd0, av & wm} << w) >> n;
        keep = wm >> n;
        tv   = ((wide >> w) & keep) | (cv & wm & ~keep);
        sv   = wide[63:0] & wm;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_big(input string req, input logic [63:0] av,
                           input logic [63:0] bv, input logic [63:0] cv);
        logic [63:0] et, es;
        ref_calc(WB, av, bv, cv, et, es);
        @(negedge clk);
        a = av; b = bv; c = cv; iv = 1'b1;
        @(negedge clk);
        iv = 1'b0;
        check({req, " valid R6"}, 64'(ov), 64'd1);
        check({req, " t"}, t, et);
        check({req, " s"}, s, es);
    endtask

    initial begin
        iv = 1'b0; a = '0; b = '0; c = '0;
        iv8 = 1'b0; a8 = '0; b8 = '0; c8 = '0;
        #12;
        // R8: reset state
        check("R8 out_valid", 64'(ov), 64'd0);
        check("R8 t", t, 64'd0);
        check("R8 s", s, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 / R2 / R3 / R4 / R5: exhaustive sweep of the 8-bit instance
        for (int ci = 0; ci < 3; ci++) begin
            for (int n = 0; n < WS; n++) begin
                for (int av = 0; av < 256; av++) begin
                    logic [63:0] et, es;
                    logic [7:0]  cv;
                    cv = (ci == 0) ? 8'h00 : (ci == 1) ? 8'hFF : 8'hA5;
                    a8 = 8'(av); b8 = 8'(n); c8 = cv; iv8 = av[0];
                    #0.1;
                    ref_calc(WS, 64'(av), 64'(n), 64'(cv), et, es);
                    check("R2 R3 small t", 64'(t8), et);
                    check("R4 small s", 64'(s8), es);
                    check("R9 small valid", 64'(ov8), 64'(av[0]));
                end
            end
        end
        // R1: upper count bits ignored on the small instance
        for (int hi = 1; hi < 32; hi++) begin
            logic [63:0] et, es;
            a8 = 8'hC3; c8 = 8'h5A; b8 = 8'({hi[4:0], 3'd5});
            #0.1;
            ref_calc(WS, 64'hC3, 64'd5, 64'h5A, et, es);
            check("R1 small t", 64'(t8), et);
            check("R1 small s", 64'(s8), es);
        end

        // Directed 64-bit cases
        run_big("R5 n=0", 64'h0123_4567_89AB_CDEF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R5 n=0 t", t, 64'h0123_4567_89AB_CDEF);
        check("R5 n=0 s", s, 64'd0);
        run_big("R2 n=1", 64'h8000_0000_0000_0003, 64'd1, 64'h8000_0000_0000_0000);
        check("R4 n=1 s", s, 64'h8000_0000_0000_0000);
        run_big("R3 n=63", 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 64'h0000_0000_0000_0001);
        check("R2 n=63 t", t, 64'h0000_0000_0000_0001);
        run_big("R4 all-ones", '1, 64'd20, '1);
        check("R4 all-ones s", s, 64'hFFFF_F000_0000_0000);
        run_big("R1 upper bits", 64'hDEAD_BEEF_0BAD_F00D, 64'hFFFF_FFFF_FFFF_FFC7, 64'h1357_9BDF_0246_8ACE);
        for (int i = 0; i < 300; i++) begin
            run_big("R2 R3 R4 random", {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
        end

        // R7: hold while idle with changing inputs
        begin
            logic [63:0] ht, hs;
            run_big("R7 prep", 64'h1111_2222_3333_4444, 64'd12, 64'hAAAA_0000_0000_0000);
            ht = t; hs = s;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                a = {$urandom, $urandom}; b = 64'(i + 3); c = {$urandom, $urandom};
            end
            @(negedge clk);
            check("R7 t hold", t, ht);
            check("R7 s hold", s, hs);
            check("R6 idle valid", 64'(ov), 64'd0);
        end

        // R3 / R4: three-word chain equals a 192-bit right shift
        begin
            logic [191:0] big, shifted;
            logic [63:0]  cy, res [3];
            big = {64'hF0E1_D2C3_B4A5_9687, 64'h7869_5A4B_3C2D_1E0F, 64'h0011_2233_4455_6677};
            cy  = '0;
            for (int wdx = 2; wdx >= 0; wdx--) begin
                run_big("R3 chain", big[wdx*64 +: 64], 64'd37, cy);
                res[wdx] = t;
                cy = s;
            end
            shifted = big >> 37;
            for (int wdx = 0; wdx < 3; wdx++) begin
                check("R3 R4 chained word", res[wdx], shifted[wdx*64 +: 64]);
            end
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got=timeout exp=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule